// File: doc/BRIEF.md
# Fractional-Period Time Counter

This block keeps a free-running time of day as a 48-bit seconds count and a nanoseconds count that always stays below one billion. On every edge of its reference clock it adds one tick period. The period is an integer number of nanoseconds plus a fraction, written as a numerator over a denominator. A remainder accumulator collects the fraction and adds one extra nanosecond whenever the fraction reaches a whole nanosecond. A 2.5 ns period, for example, is quotient 2, numerator 1 and denominator 2, and the counter then advances by 2 and by 3 on alternate ticks.

Software reaches the block through a simple synchronous register port. It can stage a new period, an absolute time or a signed nanosecond step. None of these staged values has any effect until software writes a separate commit register for it. The current time is read as three 32-bit words. Reading the nanosecond word freezes the seconds value in a snapshot, so that the two seconds words read afterwards belong to that same instant. The live time is also driven onto output ports for local timestamp consumers.

Top module: `frac_time_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the time is 0 s 0 ns, the period is the `DEF_QUO` integer nanoseconds with a zero fraction, and `per_err` is 0. The reset is asynchronous on assertion and takes effect on release after two clock edges.
- R2: On each tick the nanoseconds advance by the quotient, plus one more when the remainder accumulator plus the numerator reaches the denominator. In that case the denominator is subtracted from the accumulator.
- R3: When the nanoseconds reach 1,000,000,000 they wrap and carry one into the 48-bit seconds. The seconds change by at most one per tick, except on an absolute set.
- R4: Address 0 (quotient, low 8 bits), address 1 (numerator) and address 2 (denominator) are staged only. Writing 1 in bit 0 of address 3 commits them: the tick of that write still uses the old period, the new period applies from the next tick, and the accumulator restarts at 0.
- R5: A period commit whose denominator is 0, or whose numerator is not below the denominator, is rejected. The old period stays in force and `per_err` goes to 1. The next accepted period commit clears `per_err`.
- R6: Address 4 (nanoseconds), address 5 (seconds bits 47:32, in the low 16 bits) and address 6 (seconds bits 31:0) are staged. Writing 1 in bit 0 of address 7 loads all three together, so the next cycle shows exactly the staged time.
- R7: Address 8 stages a step: bits 28:0 hold the magnitude, bit 31 marks the step as negative, and bits 30:29 are ignored. Writing 1 in bit 0 of address 9 applies it on that tick: the new time is the old time plus the period plus or minus the magnitude.
- R8: A negative step that takes the nanoseconds below zero borrows: one second is taken from the seconds and 1,000,000,000 is added to the nanoseconds.
- R9: A read with `rd_en` returns its data with `rd_valid` one cycle later. Address 10 returns the current nanoseconds and captures the seconds into a snapshot. Address 11 (bits 47:32) and address 12 (bits 31:0) return that snapshot, however far the counter has moved since.
- R10: Staged writes, and writes to a commit address with bit 0 at 0, leave the time and the period unchanged.
- R11: An absolute-set commit whose staged nanoseconds are 1,000,000,000 or more is ignored, and the counter keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| cur_ns | output | 30 | Live nanoseconds |
| cur_sec | output | 48 | Live seconds |
| per_err | output | 1 | Last period commit was rejected |

## Verification
Several properties are checked by the assertions on every cycle:
- the nanoseconds stay below one billion;
- the remainder stays below the denominator and the denominator never becomes zero;
- a rejected period leaves the period registers unchanged;
- a valid set lands exactly;
- the seconds never jump by more than one outside a set;
- the snapshot holds between nanosecond reads.

Other behaviours show up only in the bench's scenarios, where a cycle model of the counter is compared with the live time on every cycle and with every read word:
- the fractional cadence, such as the 2/3 alternation of 2.5 ns or the 1-in-3 extra nanosecond;
- carries from seconds-low into seconds-high;
- borrows on negative steps;
- masking of the step field;
- the one-tick delay of a period commit.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  // register addresses; commit addresses follow their staged groups
  localparam logic [3:0] ADR_PER_QUO  = 4'd0;
  localparam logic [3:0] ADR_PER_NUM  = 4'd1;
  localparam logic [3:0] ADR_PER_DEN  = 4'd2;
  localparam logic [3:0] ADR_PER_CMT  = 4'd3;
  localparam logic [3:0] ADR_SET_NS   = 4'd4;
  localparam logic [3:0] ADR_SET_SECH = 4'd5;
  localparam logic [3:0] ADR_SET_SECL = 4'd6;
  localparam logic [3:0] ADR_SET_CMT  = 4'd7;
  localparam logic [3:0] ADR_STEP     = 4'd8;
  localparam logic [3:0] ADR_STEP_CMT = 4'd9;
  localparam logic [3:0] ADR_RD_NS    = 4'd10;
  localparam logic [3:0] ADR_RD_SECH  = 4'd11;
  localparam logic [3:0] ADR_RD_SECL  = 4'd12;
endpackage

// File: rtl/ftc_stage.sv
module ftc_stage
  import ftc_pkg::*;
#(
  parameter int QUO_W  = 8,
  parameter int FRAC_W = 32,
  parameter int NS_W   = 30,
  parameter int SECH_W = 16,
  parameter int SECL_W = 32,
  parameter int STEP_W = 29,
  parameter int DATA_W = 32,
  localparam int SEC_W = SECH_W + SECL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [QUO_W-1:0]  stg_quo,
  output logic [FRAC_W-1:0] stg_num,
  output logic [FRAC_W-1:0] stg_den,
  output logic              per_cmt,
  output logic [NS_W-1:0]   stg_ns,
  output logic [SEC_W-1:0]  stg_sec,
  output logic              set_cmt,
  output logic [STEP_W-1:0] stp_mag,
  output logic              stp_neg,
  output logic              stp_cmt
);
  logic [QUO_W-1:0]  quo_q, quo_n;
  logic [FRAC_W-1:0] num_q, num_n, den_q, den_n;
  logic [NS_W-1:0]   ns_q, ns_n;
  logic [SECH_W-1:0] sech_q, sech_n;
  logic [SECL_W-1:0] secl_q, secl_n;
  logic [STEP_W-1:0] mag_q, mag_n;
  logic              neg_q, neg_n;
  logic              go_bit;

  assign go_bit = wr_data[0];

  always_comb begin
    quo_n  = quo_q;
    num_n  = num_q;
    den_n  = den_q;
    ns_n   = ns_q;
    sech_n = sech_q;
    secl_n = secl_q;
    mag_n  = mag_q;
    neg_n  = neg_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_PER_QUO:  quo_n  = wr_data[QUO_W-1:0];
        ADR_PER_NUM:  num_n  = wr_data[FRAC_W-1:0];
        ADR_PER_DEN:  den_n  = wr_data[FRAC_W-1:0];
        ADR_SET_NS:   ns_n   = wr_data[NS_W-1:0];
        ADR_SET_SECH: sech_n = wr_data[SECH_W-1:0];
        ADR_SET_SECL: secl_n = wr_data[SECL_W-1:0];
        ADR_STEP: begin
          mag_n = wr_data[STEP_W-1:0];
          neg_n = wr_data[DATA_W-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      ns_q   <= '0;
      sech_q <= '0;
      secl_q <= '0;
      mag_q  <= '0;
      neg_q  <= 1'b0;
    end else if (wr_en) begin
      quo_q  <= quo_n;
      num_q  <= num_n;
      den_q  <= den_n;
      ns_q   <= ns_n;
      sech_q <= sech_n;
      secl_q <= secl_n;
      mag_q  <= mag_n;
      neg_q  <= neg_n;
    end
  end

  assign per_cmt = wr_en && (wr_addr == ADR_PER_CMT)  && go_bit;
  assign set_cmt = wr_en && (wr_addr == ADR_SET_CMT)  && go_bit;
  assign stp_cmt = wr_en && (wr_addr == ADR_STEP_CMT) && go_bit;

  assign stg_quo = quo_q;
  assign stg_num = num_q;
  assign stg_den = den_q;
  assign stg_ns  = ns_q;
  assign stg_sec = {sech_q, secl_q};
  assign stp_mag = mag_q;
  assign stp_neg = neg_q;

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({per_cmt, set_cmt, stp_cmt}) <= 1);  // R10
endmodule

// File: rtl/ftc_period.sv
module ftc_period #(
  parameter int QUO_W   = 8,
  parameter int FRAC_W  = 32,
  parameter int DEF_QUO = 20,
  localparam int INC_W  = QUO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [QUO_W-1:0]  ld_quo,
  input  logic [FRAC_W-1:0] ld_num,
  input  logic [FRAC_W-1:0] ld_den,
  output logic [INC_W-1:0]  inc,
  output logic              per_err
);
  logic [QUO_W-1:0]  quo_r, quo_n;
  logic [FRAC_W-1:0] num_r, num_n, den_r, den_n, acc_r, acc_n, acc_adv;
  logic [FRAC_W:0]   acc_sum;
  logic              ovf, ld_ok, err_r, err_n;

  always_comb begin
    acc_sum = {1'b0, acc_r} + {1'b0, num_r};
    ovf     = (acc_sum >= {1'b0, den_r});
    acc_adv = ovf ? FRAC_W'(acc_sum - {1'b0, den_r}) : FRAC_W'(acc_sum);
    inc     = {1'b0, quo_r} + INC_W'(ovf);
  end

  assign ld_ok = (ld_den != '0) && (ld_num < ld_den);

  always_comb begin
    quo_n = quo_r;
    num_n = num_r;
    den_n = den_r;
    err_n = err_r;
    acc_n = acc_adv;
    if (ld) begin
      if (ld_ok) begin
        quo_n = ld_quo;
        num_n = ld_num;
        den_n = ld_den;
        acc_n = '0;
        err_n = 1'b0;
      end else begin
        err_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r <= QUO_W'(DEF_QUO);
      num_r <= '0;
      den_r <= FRAC_W'(1);
      acc_r <= '0;
      err_r <= 1'b0;
    end else begin
      quo_r <= quo_n;
      num_r <= num_n;
      den_r <= den_n;
      acc_r <= acc_n;
      err_r <= err_n;
    end
  end

  assign per_err = err_r;

  AST_DEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    den_r != '0);  // R5
  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_r < den_r);  // R2
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_ok) |=> ($stable(quo_r) && $stable(num_r) && $stable(den_r) && per_err));  // R5
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_ok) |=> (den_r == $past(ld_den) && acc_r == '0 && !per_err));  // R4
endmodule

// File: rtl/ftc_core.sv
module ftc_core
  import ftc_pkg::*;
#(
  parameter int NS_W   = 30,
  parameter int SEC_W  = 48,
  parameter int STEP_W = 29,
  parameter int INC_W  = 9,
  localparam int SUM_W = NS_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc,
  input  logic              set_stb,
  input  logic [NS_W-1:0]   set_ns,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic              step_stb,
  input  logic              step_neg,
  input  logic [STEP_W-1:0] step_mag,
  output logic [NS_W-1:0]   ns,
  output logic [SEC_W-1:0]  sec
);
  localparam logic [SUM_W-1:0] NS1G = SUM_W'(NS_PER_SEC);

  logic [NS_W-1:0]  ns_r, ns_n;
  logic [SEC_W-1:0] sec_r, sec_n;
  logic [SUM_W-1:0] adv, mag_x, sum;
  logic             set_ok;

  assign set_ok = set_stb && (SUM_W'(set_ns) < NS1G);

  always_comb begin
    adv   = SUM_W'(ns_r) + SUM_W'(inc);
    mag_x = SUM_W'(step_mag);
    sum   = adv;
    if (step_stb) sum = step_neg ? (adv - mag_x) : (adv + mag_x);
    ns_n  = NS_W'(sum);
    sec_n = sec_r;
    if (sum[SUM_W-1]) begin
      ns_n  = NS_W'(sum + NS1G);
      sec_n = sec_r - SEC_W'(1);
    end else if (sum >= NS1G) begin
      ns_n  = NS_W'(sum - NS1G);
      sec_n = sec_r + SEC_W'(1);
    end
    if (set_ok) begin
      ns_n  = set_ns;
      sec_n = set_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_r  <= '0;
      sec_r <= '0;
    end else begin
      ns_r  <= ns_n;
      sec_r <= sec_n;
    end
  end

  assign ns  = ns_r;
  assign sec = sec_r;

  AST_NS_BELOW_1G: assert property (@(posedge clk) disable iff (!rst_n)
    SUM_W'(ns_r) < NS1G);  // R3
  AST_SET_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && SUM_W'(set_ns) < NS1G) |=> (ns == $past(set_ns) && sec == $past(set_sec)));  // R6
  AST_SEC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stb |=> (sec == $past(sec) || sec == $past(sec) + SEC_W'(1) || sec == $past(sec) - SEC_W'(1)));  // R3
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
  import ftc_pkg::*;
#(
  parameter int QUO_W   = 8,
  parameter int FRAC_W  = 32,
  parameter int NS_W    = 30,
  parameter int SECH_W  = 16,
  parameter int SECL_W  = 32,
  parameter int STEP_W  = 29,
  parameter int DATA_W  = 32,
  parameter int DEF_QUO = 20,
  localparam int SEC_W  = SECH_W + SECL_W,
  localparam int INC_W  = QUO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [NS_W-1:0]   cur_ns,
  output logic [SEC_W-1:0]  cur_sec,
  output logic              per_err
);
  logic              rs1, rs2, rst_core_n;
  logic [QUO_W-1:0]  stg_quo;
  logic [FRAC_W-1:0] stg_num, stg_den;
  logic [NS_W-1:0]   stg_ns;
  logic [SEC_W-1:0]  stg_sec;
  logic [STEP_W-1:0] stp_mag;
  logic              stp_neg, per_cmt, set_cmt, stp_cmt;
  logic [INC_W-1:0]  inc;
  logic [SEC_W-1:0]  snap_q, snap_n;
  logic [DATA_W-1:0] rdat_q, rdat_n;
  logic              vld_q, snap_ld;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end
  assign rst_core_n = rs2;

  ftc_stage #(
    .QUO_W(QUO_W), .FRAC_W(FRAC_W), .NS_W(NS_W), .SECH_W(SECH_W),
    .SECL_W(SECL_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
  ) u_stage (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stg_quo(stg_quo), .stg_num(stg_num), .stg_den(stg_den), .per_cmt(per_cmt),
    .stg_ns(stg_ns), .stg_sec(stg_sec), .set_cmt(set_cmt),
    .stp_mag(stp_mag), .stp_neg(stp_neg), .stp_cmt(stp_cmt)
  );

  ftc_period #(.QUO_W(QUO_W), .FRAC_W(FRAC_W), .DEF_QUO(DEF_QUO)) u_period (
    .clk(clk), .rst_n(rst_core_n), .ld(per_cmt), .ld_quo(stg_quo),
    .ld_num(stg_num), .ld_den(stg_den), .inc(inc), .per_err(per_err)
  );

  ftc_core #(.NS_W(NS_W), .SEC_W(SEC_W), .STEP_W(STEP_W), .INC_W(INC_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .inc(inc),
    .set_stb(set_cmt), .set_ns(stg_ns), .set_sec(stg_sec),
    .step_stb(stp_cmt), .step_neg(stp_neg), .step_mag(stp_mag),
    .ns(cur_ns), .sec(cur_sec)
  );

  // read path with coherent seconds snapshot
  assign snap_ld = rd_en && (rd_addr == ADR_RD_NS);

  always_comb begin
    snap_n = snap_ld ? cur_sec : snap_q;
    rdat_n = '0;
    if (rd_en) begin
      case (rd_addr)
        ADR_RD_NS:   rdat_n = DATA_W'(cur_ns);
        ADR_RD_SECH: rdat_n = DATA_W'(snap_q[SEC_W-1:SECL_W]);
        ADR_RD_SECL: rdat_n = DATA_W'(snap_q[SECL_W-1:0]);
        default:     rdat_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      snap_q <= '0;
      rdat_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (snap_ld) snap_q <= snap_n;
      if (rd_en)   rdat_q <= rdat_n;
      vld_q <= rd_en;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = rdat_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !snap_ld |=> $stable(snap_q));  // R9
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_core_n)
    snap_ld |=> (snap_q == $past(cur_sec)));  // R9
endmodule

// File: tb/frac_time_counter_tb.sv
module frac_time_counter_tb;
  localparam longint NSG = 1_000_000_000;
  localparam longint SECM = 64'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic        rd_valid, per_err;
  logic [31:0] rd_data;
  logic [29:0] cur_ns;
  logic [47:0] cur_sec;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  frac_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .cur_ns(cur_ns), .cur_sec(cur_sec), .per_err(per_err)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- reference model (built from the requirements)
  longint m_ns, m_sec, m_quo, m_num, m_den, m_acc;
  longint s_quo, s_num, s_den, s_ns, s_sech, s_secl, s_mag;
  bit     m_err, s_neg;
  int     m_edges;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0;
      m_ns = 0; m_sec = 0; m_quo = 20; m_num = 0; m_den = 1; m_acc = 0; m_err = 0;
      s_quo = 0; s_num = 0; s_den = 0; s_ns = 0; s_sech = 0; s_secl = 0; s_mag = 0; s_neg = 0;
    end else begin
      if (m_edges >= 2) begin
        longint inc, t;
        bit extra;
        extra = (m_acc + m_num >= m_den);
        inc = m_quo + (extra ? 1 : 0);
        m_acc = extra ? m_acc + m_num - m_den : m_acc + m_num;
        if (wr_en && wr_addr == 4'd7 && wr_data[0] && s_ns < NSG) begin
          m_ns = s_ns;
          m_sec = (s_sech << 32) | s_secl;
        end else begin
          t = m_ns + inc;
          if (wr_en && wr_addr == 4'd9 && wr_data[0]) t = s_neg ? t - s_mag : t + s_mag;
          if (t < 0) begin t += NSG; m_sec = (m_sec - 1) & SECM; end
          else if (t >= NSG) begin t -= NSG; m_sec = (m_sec + 1) & SECM; end
          m_ns = t;
        end
        if (wr_en && wr_addr == 4'd3 && wr_data[0]) begin
          if (s_den != 0 && s_num < s_den) begin
            m_quo = s_quo; m_num = s_num; m_den = s_den; m_acc = 0; m_err = 0;
          end else m_err = 1;
        end
        if (wr_en) begin
          case (wr_addr)
            4'd0: s_quo  = longint'(wr_data[7:0]);
            4'd1: s_num  = longint'(wr_data);
            4'd2: s_den  = longint'(wr_data);
            4'd4: s_ns   = longint'(wr_data[29:0]);
            4'd5: s_sech = longint'(wr_data[15:0]);
            4'd6: s_secl = longint'(wr_data);
            4'd8: begin s_mag = longint'(wr_data[28:0]); s_neg = wr_data[31]; end
            default: ;
          endcase
        end
      end
      if (m_edges < 3) m_edges++;
    end
  end

  // ---------------- scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  longint      b_snap;

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " live ns"},  longint'(cur_ns),  m_ns);
      chk({cur_req, " live sec"}, longint'(cur_sec), m_sec);
      chk({cur_req, " per_err"},  longint'(per_err), longint'(m_err));
      if (rd_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected read data", 1, 0);
        else begin
          logic [31:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(tg, longint'(rd_data), longint'(e));
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tg);
    rd_en = 1'b1; rd_addr = a;
    case (a)
      4'd10: begin exp_q.push_back(32'(m_ns)); b_snap = m_sec; end
      4'd11: exp_q.push_back(32'(b_snap >> 32));
      4'd12: exp_q.push_back(32'(b_snap & 64'hFFFF_FFFF));
      default: exp_q.push_back(32'd0);
    endcase
    tag_q.push_back(tg);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ns", longint'(cur_ns), 0);
    chk("R1 reset sec", longint'(cur_sec), 0);
    chk("R1 reset per_err", longint'(per_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 held two edges after release", longint'(cur_ns), 0);
    cur_req = "R2";
    repeat (20) @(negedge clk);
    rd(4'd10, "R9 ns read default period");

    cur_req = "R10";
    wr(4'd0, 32'd2); wr(4'd1, 32'd1); wr(4'd2, 32'd2);
    wr(4'd3, 32'd0); wr(4'd8, 32'd5000); wr(4'd4, 32'd123);
    wr(4'd7, 32'd2); wr(4'd9, 32'd0);
    repeat (10) @(negedge clk);

    cur_req = "R4";
    wr(4'd3, 32'd1);
    repeat (20) @(negedge clk);

    cur_req = "R5";
    wr(4'd2, 32'd0); wr(4'd3, 32'd1);
    chk("R5 zero denominator flagged", longint'(per_err), 1);
    repeat (5) @(negedge clk);
    wr(4'd1, 32'd3); wr(4'd2, 32'd3); wr(4'd3, 32'd1);
    chk("R5 numerator not below denominator flagged", longint'(per_err), 1);
    wr(4'd1, 32'd1); wr(4'd3, 32'd1);
    chk("R5 accepted commit clears flag", longint'(per_err), 0);
    cur_req = "R2";
    repeat (30) @(negedge clk);

    cur_req = "R3";
    wr(4'd0, 32'd20); wr(4'd1, 32'd0); wr(4'd2, 32'd1); wr(4'd3, 32'd1);
    wr(4'd4, 32'd999_999_900); wr(4'd5, 32'h0000_0001); wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'd1);
    chk("R6 set lands", longint'(cur_sec), 64'h1_FFFF_FFFF);
    repeat (12) @(negedge clk);
    chk("R3 carry into seconds high", longint'(cur_sec), 64'h2_0000_0000);

    cur_req = "R11";
    wr(4'd4, 32'd1_000_000_000); wr(4'd7, 32'd1);
    repeat (3) @(negedge clk);

    cur_req = "R9";
    wr(4'd4, 32'd999_999_000); wr(4'd7, 32'd1);
    rd(4'd10, "R9 ns read before rollover");
    repeat (100) @(negedge clk);
    rd(4'd11, "R9 snapshot seconds high");
    rd(4'd12, "R9 snapshot seconds low");
    chk("R9 live seconds moved on", longint'(cur_sec), 64'h2_0000_0000);

    cur_req = "R7";
    wr(4'd8, 32'd1000); wr(4'd9, 32'd1);
    repeat (5) @(negedge clk);
    wr(4'd8, 32'h6000_0100); wr(4'd9, 32'd1);
    wr(4'd4, 32'd999_999_000); wr(4'd7, 32'd1);
    wr(4'd8, 32'd5000); wr(4'd9, 32'd1);
    repeat (5) @(negedge clk);

    cur_req = "R8";
    wr(4'd4, 32'd100); wr(4'd5, 32'd0); wr(4'd6, 32'd5); wr(4'd7, 32'd1);
    wr(4'd8, 32'h8000_2710); wr(4'd9, 32'd1);
    chk("R8 borrow decrements seconds", longint'(cur_sec), 4);
    repeat (3) @(negedge clk);
    wr(4'd8, 32'h8000_0064); wr(4'd9, 32'd1);
    repeat (5) @(negedge clk);
    rd(4'd10, "R9 ns after borrow");
    rd(4'd12, "R9 seconds low after borrow");
    repeat (4) @(negedge clk);
    chk("R9 all reads returned", longint'(exp_q.size()), 0);
    finish_up();
  end
endmodule